// File: doc/BRIEF.md
# Floating-Point Significand-and-Exponent Multiplier

This block multiplies two binary floating-point operands held in the usual packed layout and returns the packed product together with two range flags. The work is purely combinational. For each operand it splits out the sign, exponent and stored fraction and puts the implied leading one back in front of the fraction. It then multiplies the two significands, combines the signs by exclusive-OR and adds the biased exponents with one bias removed. A one-place right normalisation follows when the product reaches two or more. The fraction is cut to the stored width by dropping the low bits. Only normal operands are handled. No rounding mode other than truncation is offered, and special values receive no treatment.

Exponent and fraction widths are parameters. The default is the 64-bit format with an 11-bit exponent and a 52-bit fraction. A narrow configuration with an 8-bit exponent and a 5-bit fraction serves for hand-checked cases. A parameter selects how the significand product is built: either the synthesis multiply operator or an explicit shift-and-add array of partial-product rows.

Operands arrive on a valid/ready stream and leave on one. The block holds no storage, so a transfer on the input side happens in the same cycle as the matching transfer on the output side. Back-pressure passes straight through: `in_ready` follows `out_ready`, and `out_valid` follows `in_valid`. A producer that is stalled must hold its operands steady, and the result then stays steady as well.

Top module: `fpm_mult`

## Requirements
- R1: An operand or result word has the sign at its most significant bit, the exponent in the next EW bits and the fraction in the FW least significant bits.
- R2: For each normal operand the significand is the stored fraction with a 1 placed above its most significant bit, so 1.0 times x returns x unchanged.
- R3: The result sign equals the exclusive-OR of the two operand signs.
- R4: When the significand product is below two, the result exponent is E_A + E_B − bias, where bias is 2^(EW−1) − 1 (1023 for EW=11, 127 for EW=8).
- R5: When the significand product is two or more, it is shifted right one place and the result exponent is E_A + E_B − bias + 1.
- R6: The result fraction is the FW bits directly below the leading one of the normalised product, and every lower bit is discarded (truncation).
- R7: `ovf` is 1 when the final biased exponent is 2^EW − 1 or greater. It is 0 otherwise, and it is never 1 together with `unf`.
- R8: `unf` is 1 when the final biased exponent is zero or negative. It is 0 otherwise.
- R9: `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`, in the same cycle. While the operands are held during a stall, the result and the flags stay unchanged.
- R10: With EW=8 and FW=5, 0 10000001 01100 times 1 10000100 00011 gives 1 10000110 10000. With the default EW=11 and FW=52, the results follow R2 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take the operand pair (follows out_ready) |
| op_a | input | 1+EW+FW | First packed operand |
| op_b | input | 1+EW+FW | Second packed operand |
| out_valid | output | 1 | Product present (follows in_valid) |
| out_ready | input | 1 | Consumer takes the product |
| out_result | output | 1+EW+FW | Packed product; exponent and fraction undefined when a flag is set |
| out_ovf | output | 1 | Result exponent too large for the format |
| out_unf | output | 1 | Result exponent zero or below |

## Verification
The embedded checks assume that every operand pair offered with `in_valid` high is normal, with an exponent field that is neither all zeros nor all ones. Under that assumption both significands carry a leading one, the product falls between one and four, and the normalisation step needs at most a single place. The bench therefore offers only exponents in the open range when it raises `in_valid`, and it drops `in_valid` whenever it changes operands outside a tested transfer. Where a result overflows or underflows, the bench checks only the flag.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [0:0] {
    MUL_OPERATOR = 1'b0,
    MUL_ROWS     = 1'b1
  } mul_style_e;

  function automatic int exp_bias(input int ew);
    return (1 << (ew - 1)) - 1;
  endfunction

  function automatic int exp_all_ones(input int ew);
    return (1 << ew) - 1;
  endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
  parameter int EW = 11,
  parameter int FW = 52,
  localparam int W  = 1 + EW + FW,
  localparam int SW = FW + 1
) (
  input  logic          chk_en,
  input  logic [W-1:0]  word,
  output logic          sign,
  output logic [EW-1:0] expo,
  output logic [SW-1:0] sig
);
  localparam int EMAX = fpm_pkg::exp_all_ones(EW);

  assign sign = word[W-1];
  assign expo = word[W-2 -: EW];
  assign sig  = {1'b1, word[FW-1:0]};

  always_comb begin
    if (chk_en) begin
      AST_OPERAND_NORMAL: assert (expo != '0 && expo != EW'(EMAX)); // R2
    end
  end
endmodule

// File: rtl/fpm_sig_mul.sv
module fpm_sig_mul #(
  parameter int SW = 53,
  parameter fpm_pkg::mul_style_e STYLE = fpm_pkg::MUL_OPERATOR,
  localparam int PW = 2 * SW
) (
  input  logic          chk_en,
  input  logic [SW-1:0] sig_a,
  input  logic [SW-1:0] sig_b,
  output logic [PW-1:0] prod
);
  generate
    if (STYLE == fpm_pkg::MUL_OPERATOR) begin : g_op
      assign prod = PW'(sig_a) * PW'(sig_b);
    end else begin : g_rows
      logic [PW-1:0] acc [SW+1];
      assign acc[0] = '0;
      for (genvar i = 0; i < SW; i++) begin : g_row
        logic [PW-1:0] pp;
        assign pp         = sig_b[i] ? (PW'(sig_a) << i) : '0;
        assign acc[i + 1] = acc[i] + pp;
      end
      assign prod = acc[SW];
    end
  endgenerate

  always_comb begin
    if (chk_en && sig_a[SW-1] && sig_b[SW-1]) begin
      AST_PROD_RANGE: assert (prod[PW-1:PW-2] != 2'b00); // R5
    end
  end
endmodule

// File: rtl/fpm_norm.sv
module fpm_norm #(
  parameter int FW = 52,
  localparam int SW = FW + 1,
  localparam int PW = 2 * SW
) (
  input  logic          chk_en,
  input  logic [PW-1:0] prod,
  output logic          shift,
  output logic [FW-1:0] frac
);
  assign shift = prod[PW-1];
  assign frac  = shift ? prod[PW-2 -: FW] : prod[PW-3 -: FW];

  always_comb begin
    if (chk_en && !shift) begin
      AST_LEAD_ONE: assert (prod[PW-2]); // R6
    end
  end
endmodule

// File: rtl/fpm_exp.sv
module fpm_exp #(
  parameter int EW = 11,
  localparam int XW = EW + 2
) (
  input  logic          chk_en,
  input  logic [EW-1:0] exp_a,
  input  logic [EW-1:0] exp_b,
  input  logic          shift,
  output logic [EW-1:0] exp_out,
  output logic          ovf,
  output logic          unf
);
  localparam int BIAS = fpm_pkg::exp_bias(EW);
  localparam int EMAX = fpm_pkg::exp_all_ones(EW);
  localparam logic signed [XW-1:0] BIAS_S = XW'(BIAS);
  localparam logic signed [XW-1:0] EMAX_S = XW'(EMAX);
  localparam logic signed [XW-1:0] ZERO_S = '0;

  logic signed [XW-1:0] ea_x, eb_x, sh_x, sum;

  assign ea_x    = {2'b00, exp_a};
  assign eb_x    = {2'b00, exp_b};
  assign sh_x    = {{(XW-1){1'b0}}, shift};
  assign sum     = ea_x + eb_x - BIAS_S + sh_x;
  assign ovf     = (sum >= EMAX_S);
  assign unf     = (sum <= ZERO_S);
  assign exp_out = sum[EW-1:0];

  always_comb begin
    if (chk_en) begin
      AST_FLAGS_EXCL: assert (!(ovf && unf)); // R7
      if (!ovf && !unf) begin
        AST_EXP_IN_RANGE: assert (exp_out != '0 && exp_out != EW'(EMAX)); // R8
      end
    end
  end
endmodule

// File: rtl/fpm_mult.sv
module fpm_mult #(
  parameter int EW = 11,
  parameter int FW = 52,
  parameter fpm_pkg::mul_style_e MUL_STYLE = fpm_pkg::MUL_OPERATOR,
  localparam int W  = 1 + EW + FW,
  localparam int SW = FW + 1,
  localparam int PW = 2 * SW
) (
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_ovf,
  output logic         out_unf
);
  logic          s_a, s_b;
  logic [EW-1:0] e_a, e_b, e_r;
  logic [SW-1:0] m_a, m_b;
  logic [PW-1:0] prod;
  logic          shift;
  logic [FW-1:0] frac;

  fpm_unpack #(.EW(EW), .FW(FW)) u_unpack_a (
    .chk_en(in_valid), .word(op_a), .sign(s_a), .expo(e_a), .sig(m_a)
  );

  fpm_unpack #(.EW(EW), .FW(FW)) u_unpack_b (
    .chk_en(in_valid), .word(op_b), .sign(s_b), .expo(e_b), .sig(m_b)
  );

  fpm_sig_mul #(.SW(SW), .STYLE(MUL_STYLE)) u_sig_mul (
    .chk_en(in_valid), .sig_a(m_a), .sig_b(m_b), .prod(prod)
  );

  fpm_norm #(.FW(FW)) u_norm (
    .chk_en(in_valid), .prod(prod), .shift(shift), .frac(frac)
  );

  fpm_exp #(.EW(EW)) u_exp (
    .chk_en(in_valid), .exp_a(e_a), .exp_b(e_b), .shift(shift),
    .exp_out(e_r), .ovf(out_ovf), .unf(out_unf)
  );

  assign out_result = {s_a ^ s_b, e_r, frac};
  assign out_valid  = in_valid;
  assign in_ready   = out_ready;
endmodule

// File: tb/test_fpm_mult.sv
module test_fpm_mult;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks   = 0;
  int failures = 0;

  // default 64-bit configuration, row-array multiplier
  logic        d_vi = 1'b0, d_ro = 1'b1, d_ri, d_vo, d_ovf, d_unf;
  logic [63:0] d_a = '0, d_b = '0, d_res;

  fpm_mult #(.MUL_STYLE(fpm_pkg::MUL_ROWS)) i_fpm_mult (
    .in_valid(d_vi), .in_ready(d_ri), .op_a(d_a), .op_b(d_b),
    .out_valid(d_vo), .out_ready(d_ro), .out_result(d_res),
    .out_ovf(d_ovf), .out_unf(d_unf)
  );

  // narrow configuration
  logic        s_vi = 1'b0, s_ro = 1'b1, s_ri, s_vo, s_ovf, s_unf;
  logic [13:0] s_a = '0, s_b = '0, s_res;

  fpm_mult #(.EW(8), .FW(5)) i_fpm_mult_small (
    .in_valid(s_vi), .in_ready(s_ri), .op_a(s_a), .op_b(s_b),
    .out_valid(s_vo), .out_ready(s_ro), .out_result(s_res),
    .out_ovf(s_ovf), .out_unf(s_unf)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model: wide product, one-step normalise, truncate
  function automatic void model(input int ew, input int fw, input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] r, output bit ov, output bit un);
    logic [127:0] sa, sb, p;
    longint ea, eb, e, top;
    logic [63:0] fmask, emask, fr;
    fmask = (64'd1 << fw) - 1;
    emask = (64'd1 << ew) - 1;
    ea = longint'((a >> fw) & emask);
    eb = longint'((b >> fw) & emask);
    sa = (128'd1 << fw) | 128'(a & fmask);
    sb = (128'd1 << fw) | 128'(b & fmask);
    p = sa * sb;
    top = longint'(p[2*fw+1]);
    e = ea + eb - ((longint'(1) << (ew - 1)) - 1) + top;
    fr = 64'(p >> (fw + top)) & fmask;
    ov = (e >= longint'(emask));
    un = (e <= 0);
    r = (64'(a[ew+fw] ^ b[ew+fw]) << (ew + fw)) | ((64'(e) & emask) << fw) | fr;
  endfunction

  task automatic judge(input int ew, input int fw, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] res, input bit ovf, input bit unf, input string req);
    logic [63:0] r;
    bit ov, un;
    model(ew, fw, a, b, r, ov, un);
    if (ov) chk(ovf == 1'b1, {req, " R7 ovf"}, 64'(ovf), 64'd1);
    else if (un) chk(unf == 1'b1, {req, " R8 unf"}, 64'(unf), 64'd1);
    else begin
      chk(res == r, {req, " result"}, res, r);
      chk({ovf, unf} == 2'b00, {req, " R7/R8 flags clear"}, 64'({ovf, unf}), 64'd0);
    end
  endtask

  task automatic run_d(input logic [63:0] a, input logic [63:0] b, input string req);
    @(posedge clk); #1;
    d_a = a; d_b = b; d_vi = 1'b1;
    @(negedge clk);
    judge(11, 52, a, b, d_res, d_ovf, d_unf, req);
  endtask

  task automatic run_s(input logic [13:0] a, input logic [13:0] b, input string req);
    @(posedge clk); #1;
    s_a = a; s_b = b; s_vi = 1'b1;
    @(negedge clk);
    judge(8, 5, 64'(a), 64'(b), 64'(s_res), s_ovf, s_unf, req);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk(d_vo == 1'b0, "R9 idle out_valid", 64'(d_vo), 64'd0);
    chk(s_vo == 1'b0, "R9 idle out_valid small", 64'(s_vo), 64'd0);
  endtask

  task automatic t_example;
    run_s(14'b0_10000001_01100, 14'b1_10000100_00011, "R10 example");
    chk(s_res == 14'b1_10000110_10000, "R10 R3 R4 R6 example exact", 64'(s_res), 64'(14'b1_10000110_10000));
  endtask

  task automatic t_shift;
    run_s(14'b0_01111111_10000, 14'b0_01111111_10000, "R5 1.5x1.5");
    chk(s_res == 14'b0_10000000_00100, "R5 shift exact", 64'(s_res), 64'(14'b0_10000000_00100));
  endtask

  task automatic t_trunc;
    run_s(14'b1_01111111_11111, 14'b0_01111111_11111, "R6 all-ones fractions");
    chk(s_res == 14'b1_10000000_11110, "R6 truncation exact", 64'(s_res), 64'(14'b1_10000000_11110));
  endtask

  task automatic t_identity;
    run_d(64'h3FF0000000000000, 64'hC00921FB54442D18, "R2 one times x");
    chk(d_res == 64'hC00921FB54442D18, "R2 R1 identity exact", d_res, 64'hC00921FB54442D18);
    run_d(64'hBFF0000000000000, 64'hC00921FB54442D18, "R3 minus one times x");
    chk(d_res == 64'h400921FB54442D18, "R3 sign flip exact", d_res, 64'h400921FB54442D18);
  endtask

  task automatic t_bounds;
    run_d({1'b0, 11'd2046, 52'd0}, {1'b0, 11'd1023, 52'd0}, "R7 just below top");
    chk(d_ovf == 1'b0 && d_res[62:52] == 11'd2046, "R7 R4 exp 2046", 64'(d_res[62:52]), 64'd2046);
    run_d({1'b0, 11'd2046, 52'd0}, {1'b0, 11'd1024, 52'd0}, "R7 sum at top");
    chk(d_ovf == 1'b1, "R7 overflow at all-ones", 64'(d_ovf), 64'd1);
    run_d({1'b0, 11'd2046, 1'b1, 51'd0}, {1'b0, 11'd1023, 1'b1, 51'd0}, "R7 overflow by shift");
    chk(d_ovf == 1'b1, "R5 R7 shift pushes to overflow", 64'(d_ovf), 64'd1);
    run_d({1'b0, 11'd1, 52'd0}, {1'b1, 11'd1022, 52'd0}, "R8 sum zero");
    chk(d_unf == 1'b1, "R8 underflow at zero", 64'(d_unf), 64'd1);
    run_d({1'b0, 11'd1, 52'd0}, {1'b1, 11'd1023, 52'd0}, "R8 sum one");
    chk(d_unf == 1'b0 && d_res[62:52] == 11'd1, "R8 exp 1 kept", 64'(d_res[62:52]), 64'd1);
    run_s(14'b0_00000001_00000, 14'b0_01111110_10000, "R8 small one-step above zero");
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      a = {1'($urandom), 11'(723 + ($urandom % 600)), $urandom, 20'($urandom)};
      b = {1'($urandom), 11'(723 + ($urandom % 600)), $urandom, 20'($urandom)};
      run_d(a, b, "R4 R5 R6 random double");
    end
    for (int i = 0; i < 300; i++) begin
      logic [13:0] a, b;
      a = {1'($urandom), 8'(1 + ($urandom % 254)), 5'($urandom)};
      b = {1'($urandom), 8'(1 + ($urandom % 254)), 5'($urandom)};
      run_s(a, b, "R7 R8 random narrow");
    end
  endtask

  task automatic t_handshake;
    logic [63:0] held;
    run_d(64'h4008000000000000, 64'h3FF8000000000000, "R9 stall setup");
    held = d_res;
    #1 d_ro = 1'b0;
    @(negedge clk);
    chk(d_ri == 1'b0, "R9 ready follows stall", 64'(d_ri), 64'd0);
    chk(d_vo == 1'b1, "R9 valid held", 64'(d_vo), 64'd1);
    @(negedge clk);
    chk(d_res == held, "R9 result stable in stall", d_res, held);
    d_ro = 1'b1;
    #1 chk(d_ri == 1'b1, "R9 ready restored", 64'(d_ri), 64'd1);
    d_vi = 1'b0;
    #1 chk(d_vo == 1'b0, "R9 valid drops", 64'(d_vo), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_idle();
    t_example();
    t_shift();
    t_trunc();
    t_identity();
    t_bounds();
    t_random();
    t_handshake();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule